// File: doc/BRIEF.md
# Supply Voltage Detector Sampling Controller

This block runs a 4-bit successive-approximation measurement of the supply voltage. It works with an external comparator and a reference-level selector. The block drives a trial code to the reference generator. On each decision it samples the comparator, and when the last bit is decided it writes the code into a result register. Software controls the block through two control bits, written together with one strobe:

- an enable bit, which selects continuous sampling;
- a select bit, which selects auto-sampling paced by a slow 1/4 Hz tick.

While a conversion runs, the enable bit reads back as a busy flag.

The bit decisions are paced by a 2048 Hz sampling tick. A sleep request that arrives during a conversion waits: the oscillator-stop grant is held back until the conversion ends. During that wait, hardware clears both control bits. A mask-option strap can turn a completed level-0 result into an initial-reset request.

Top module: `vdet_ctrl`

## Requirements
- R1: Mode decode. With the enable bit at 0 and the select bit at 0 the block is off, and no tick starts a conversion. With the enable bit at 1 it samples continuously, whatever the select bit holds. With the enable bit at 0 and the select bit at 1 it auto-samples.
- R2: `busy_o` rises on the clock edge that starts a conversion. It stays at 1 until the edge that commits the result, and is 0 otherwise.
- R3: A conversion takes 16 sampling ticks after its start tick. Each bit decision uses 4 ticks, and the 16th tick commits the result.
- R4: The trial code starts at 4'b1000 and bits are decided MSB first. A bit is kept when `cmp_hi_i` is 1, meaning the supply is at or above the trial level; otherwise it is cleared. The committed result therefore equals the supply level, 0 to 15.
- R5: `level_o` changes only on the edge where a conversion commits. During a conversion it holds the previous result.
- R6: In auto mode a conversion starts only on a `tick_slow_i` pulse that arrives while the block is idle. Sampling ticks alone never start one.
- R7: In continuous mode a new conversion starts on the first sampling tick after the previous one commits.
- R8: If `sleep_req_i` is high while a conversion runs, `osc_stop_o` stays 0 until that conversion commits. It rises one clock after `busy_o` falls.
- R9: While `sleep_req_i` is high during a conversion, both control bits are forced to 0 and control writes are overridden. Once the block is idle it stays idle.
- R10: Clearing both control bits in the middle of a conversion lets that conversion finish and commit its result. The block then stays idle.
- R11: A sleep request made while idle is granted on the next clock. No conversion starts while `sleep_req_i` is high.
- R12: When `rst_opt_i` is 1 and a conversion commits level 0, `por_req_o` goes high and holds until the next commit. With `rst_opt_i` at 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Write strobe for the two control bits |
| ctl_en_i | input | 1 | Enable bit write data (continuous mode) |
| ctl_sel_i | input | 1 | Select bit write data (auto mode) |
| tick_fast_i | input | 1 | One-cycle 2048 Hz sampling tick |
| tick_slow_i | input | 1 | One-cycle 1/4 Hz auto-sampling tick |
| cmp_hi_i | input | 1 | Comparator: supply at or above trial level |
| sleep_req_i | input | 1 | Oscillator-stop request, level |
| rst_opt_i | input | 1 | Strap enabling the level-0 reset request |
| trial_o | output | 4 | Trial code to the reference selector |
| level_o | output | 4 | Last committed result |
| busy_o | output | 1 | Enable-bit readback: 1 while converting |
| sel_o | output | 1 | Select-bit readback |
| osc_stop_o | output | 1 | Oscillator-stop grant |
| por_req_o | output | 1 | Initial-reset request on a level-0 result |

## Verification
The assertions assume the following about the inputs:

- both ticks are single-cycle pulses;
- the comparator answer is valid in the cycle a decision is taken;
- the strap is steady across the commit edge.

The bench keeps to these assumptions:

- it issues sampling ticks one clock wide, every fourth clock;
- it drives the slow tick as a lone one-cycle pulse;
- it derives the comparator combinationally from the trial code and a modelled supply level;
- it changes the strap only while the block is idle.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_AUTO = 2'd1,
    MODE_CONT = 2'd2
  } vdet_mode_e;

  function automatic vdet_mode_e decode_mode(input logic en, input logic sel);
    if (en)       return MODE_CONT;
    else if (sel) return MODE_AUTO;
    else          return MODE_OFF;
  endfunction
endpackage

// File: rtl/vdet_ctl_regs.sv
module vdet_ctl_regs
  import vdet_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       en_wr_i,
  input  logic       sel_wr_i,
  input  logic       sleep_req_i,
  input  logic       busy_i,
  output logic       sel_o,
  output vdet_mode_e mode_o
);
  logic en_q, sel_q;
  logic hw_clr;

  // hardware clear while a sleep waits on a running conversion
  assign hw_clr = sleep_req_i && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (hw_clr) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (we_i) begin
      en_q  <= en_wr_i;
      sel_q <= sel_wr_i;
    end
  end

  assign sel_o  = sel_q;
  assign mode_o = decode_mode(en_q, sel_q);

  assert_ctl_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && busy_i) |=> (mode_o == MODE_OFF));
endmodule

// File: rtl/vdet_sar.sv
module vdet_sar
  import vdet_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned TICKS_PER_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vdet_mode_e        mode_i,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  input  logic              hold_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] trial_o,
  output logic [CODE_W-1:0] level_o,
  output logic              busy_o,
  output logic              commit_o,
  output logic [CODE_W-1:0] commit_val_o
);
  localparam int unsigned CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned IW = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TICKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_TOP  = IW'(CODE_W - 1);
  localparam logic [CODE_W-1:0] TRIAL_INIT = {1'b1, {(CODE_W-1){1'b0}}};

  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [CODE_W-1:0] trial_q, trial_nxt, level_q;
  logic              start, decide;

  assign start = !busy_q && !hold_i &&
                 (((mode_i == MODE_CONT) && tick_fast_i) ||
                  ((mode_i == MODE_AUTO) && tick_slow_i));
  assign decide   = busy_q && tick_fast_i && (cnt_q == CNT_LAST);
  assign commit_o = decide && (idx_q == '0);

  always_comb begin
    trial_nxt = trial_q;
    if (decide) begin
      trial_nxt[idx_q] = cmp_i;
      if (idx_q != '0) trial_nxt[idx_q - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      trial_q <= '0;
      level_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      idx_q   <= IDX_TOP;
      trial_q <= TRIAL_INIT;
    end else if (busy_q && tick_fast_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        trial_q <= trial_nxt;
        if (idx_q == '0) begin
          busy_q  <= 1'b0;
          level_q <= trial_nxt;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign trial_o      = trial_q;
  assign level_o      = level_q;
  assign busy_o       = busy_q;
  assign commit_val_o = trial_nxt;

  assert_trial_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (trial_q == TRIAL_INIT));
  assert_level_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> $fell(busy_q));
  assert_no_start_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !busy_q) |=> !busy_q);
  assert_off_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !busy_q) |=> !busy_q);
endmodule

// File: rtl/vdet_guard.sv
module vdet_guard #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              busy_i,
  input  logic              commit_i,
  input  logic [CODE_W-1:0] commit_val_i,
  input  logic [CODE_W-1:0] level_i,
  input  logic              strap_i,
  output logic              osc_stop_o,
  output logic              por_req_o
);
  logic osc_q, por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q <= 1'b0;
      por_q <= 1'b0;
    end else begin
      osc_q <= sleep_req_i && !busy_i;
      if (commit_i) por_q <= strap_i && (commit_val_i == '0);
    end
  end

  assign osc_stop_o = osc_q;
  assign por_req_o  = por_q;

  assert_grant_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !osc_stop_o);
  assert_por_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_q) |-> ($past(strap_i) && (level_i == '0)));
endmodule

// File: rtl/vdet_ctrl.sv
module vdet_ctrl
  import vdet_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned TICKS_PER_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              ctl_en_i,
  input  logic              ctl_sel_i,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  input  logic              cmp_hi_i,
  input  logic              sleep_req_i,
  input  logic              rst_opt_i,
  output logic [CODE_W-1:0] trial_o,
  output logic [CODE_W-1:0] level_o,
  output logic              busy_o,
  output logic              sel_o,
  output logic              osc_stop_o,
  output logic              por_req_o
);
  vdet_mode_e        mode;
  logic              busy, commit;
  logic [CODE_W-1:0] commit_val, level;

  vdet_ctl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctl_we_i),
    .en_wr_i     (ctl_en_i),
    .sel_wr_i    (ctl_sel_i),
    .sleep_req_i (sleep_req_i),
    .busy_i      (busy),
    .sel_o       (sel_o),
    .mode_o      (mode)
  );

  vdet_sar #(.CODE_W(CODE_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_sar (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .tick_fast_i  (tick_fast_i),
    .tick_slow_i  (tick_slow_i),
    .hold_i       (sleep_req_i),
    .cmp_i        (cmp_hi_i),
    .trial_o      (trial_o),
    .level_o      (level),
    .busy_o       (busy),
    .commit_o     (commit),
    .commit_val_o (commit_val)
  );

  vdet_guard #(.CODE_W(CODE_W)) u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .busy_i       (busy),
    .commit_i     (commit),
    .commit_val_i (commit_val),
    .level_i      (level),
    .strap_i      (rst_opt_i),
    .osc_stop_o   (osc_stop_o),
    .por_req_o    (por_req_o)
  );

  assign busy_o  = busy;
  assign level_o = level;
endmodule

// File: tb/tb_vdet_ctrl.sv
module tb_vdet_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_en = 1'b0, ctl_sel = 1'b0;
  logic tick_fast = 1'b0, tick_slow = 1'b0;
  logic sleep_req = 1'b0, strap = 1'b0;
  logic cmp;
  logic [3:0] trial, level;
  logic busy, sel, osc_stop, por_req;
  logic [3:0] vsup = 4'd0;
  bit tick_on = 1'b0;
  int total = 0, bad = 0;
  int bt = 0, it = 0;

  always #10 clk = ~clk;

  // comparator model: supply at or above trial level
  assign cmp = (vsup >= trial);

  vdet_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_en_i(ctl_en),
    .ctl_sel_i(ctl_sel), .tick_fast_i(tick_fast), .tick_slow_i(tick_slow),
    .cmp_hi_i(cmp), .sleep_req_i(sleep_req), .rst_opt_i(strap),
    .trial_o(trial), .level_o(level), .busy_o(busy), .sel_o(sel),
    .osc_stop_o(osc_stop), .por_req_o(por_req)
  );

  // entries: {en, sel, supply[3:0]}
  localparam logic [5:0] VEC [8] = '{
    {2'b10, 4'd5}, {2'b11, 4'd0}, {2'b10, 4'd15}, {2'b01, 4'd9},
    {2'b10, 4'd8}, {2'b11, 4'd7}, {2'b01, 4'd1},  {2'b10, 4'd10}
  };

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick_fast = tick_on && (ph == 0);
      if (tick_fast && busy)  bt++;
      if (tick_fast && !busy) it++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic s);
    @(negedge clk); ctl_we = 1'b1; ctl_en = en; ctl_sel = s;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic slow_pulse();
    @(negedge clk); tick_slow = 1'b1;
    @(negedge clk); tick_slow = 1'b0;
  endtask

  task automatic wait_busy(input logic v, input int lim);
    for (int i = 0; i < lim && busy !== v; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [3:0] prev;
    bit en_b, sel_b;
    repeat (3) @(negedge clk);
    // reset state
    chk("R2 reset busy", busy, 0);
    chk("R5 reset level", level, 0);
    chk("R8 reset grant", osc_stop, 0);
    chk("R12 reset por", por_req, 0);
    chk("R9 reset sel", sel, 0);
    rst_n = 1'b1;
    tick_on = 1'b1;

    // table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      en_b  = VEC[k][5];
      sel_b = VEC[k][4];
      vsup  = VEC[k][3:0];
      prev  = level;
      bt = 0;
      wr(en_b, sel_b);
      if (!en_b) slow_pulse();
      wait_busy(1'b1, 40);
      chk("R1 R2 start busy", busy, 1);
      while (bt < 8) @(negedge clk);
      chk("R5 mid-conversion level", level, prev);
      wait_busy(1'b0, 200);
      chk("R4 result", level, vsup);
      chk("R3 tick count", bt, 16);
      chk("R12 no por without strap", por_req, 0);
      wr(1'b0, 1'b0);
      idle(4);
    end

    // R1 off mode ignores ticks
    wr(1'b0, 1'b0);
    slow_pulse();
    idle(40);
    chk("R1 off stays idle", busy, 0);

    // R6 auto waits for slow tick
    vsup = 4'd3;
    wr(1'b0, 1'b1);
    idle(60);
    chk("R6 no start on fast ticks", busy, 0);
    slow_pulse();
    chk("R6 start on slow tick", busy, 1);
    wait_busy(1'b0, 200);
    chk("R6 result", level, 3);
    idle(30);
    chk("R6 idle after one conversion", busy, 0);
    wr(1'b0, 1'b0);

    // R7 continuous restarts on next tick
    vsup = 4'd6;
    wr(1'b1, 1'b0);
    wait_busy(1'b1, 40);
    wait_busy(1'b0, 200);
    it = 0;
    wait_busy(1'b1, 20);
    chk("R7 restart", busy, 1);
    chk("R7 restart tick", it, 1);
    wr(1'b0, 1'b0);
    wait_busy(1'b0, 200);

    // R10 clear mid-conversion
    idle(8);
    vsup = 4'd11;
    bt = 0;
    wr(1'b1, 1'b0);
    wait_busy(1'b1, 40);
    while (bt < 5) @(negedge clk);
    wr(1'b0, 1'b0);
    chk("R10 still busy after clear", busy, 1);
    wait_busy(1'b0, 200);
    chk("R10 result committed", level, 11);
    idle(40);
    chk("R10 idle afterwards", busy, 0);

    // R8 R9 sleep during conversion
    vsup = 4'd13;
    bt = 0;
    wr(1'b1, 1'b1);
    wait_busy(1'b1, 40);
    while (bt < 6) @(negedge clk);
    sleep_req = 1'b1;
    idle(2);
    chk("R9 sel cleared", sel, 0);
    wr(1'b1, 1'b1);
    idle(1);
    chk("R9 write overridden", sel, 0);
    begin
      int early;
      early = 0;
      while (busy) begin
        if (osc_stop) early++;
        @(negedge clk);
      end
      chk("R8 grant withheld", early, 0);
    end
    chk("R8 grant not same cycle", osc_stop, 0);
    @(negedge clk);
    chk("R8 grant after commit", osc_stop, 1);
    chk("R8 result", level, 13);
    idle(20);
    sleep_req = 1'b0;
    idle(40);
    chk("R9 stays idle", busy, 0);
    chk("R8 grant released", osc_stop, 0);

    // R11 idle sleep
    sleep_req = 1'b1;
    @(negedge clk);
    chk("R11 grant next clock", osc_stop, 1);
    wr(1'b0, 1'b1);
    slow_pulse();
    idle(20);
    chk("R11 no start while sleeping", busy, 0);
    wr(1'b0, 1'b0);
    sleep_req = 1'b0;
    idle(2);

    // R12 strap and level 0
    strap = 1'b1;
    vsup = 4'd0;
    wr(1'b1, 1'b0);
    wait_busy(1'b1, 40);
    wr(1'b0, 1'b0);
    wait_busy(1'b0, 200);
    chk("R12 por on level 0", por_req, 1);
    idle(10);
    chk("R12 por held", por_req, 1);
    vsup = 4'd2;
    wr(1'b0, 1'b1);
    slow_pulse();
    wait_busy(1'b0, 200);
    wr(1'b0, 1'b0);
    chk("R12 por cleared on nonzero", por_req, 0);
    strap = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule